// File: doc/BRIEF.md
# NMI Source Latch and Legacy Control Ports

This block gathers non-maskable interrupt requests from the board and produces one NMI line for the processor. Three request paths feed it: an active-low I/O channel check, the active-low PCI system-error and parity-error lines (combined into one parity source), and an active-high processor internal-error line. The two latched sources each keep a pending flag. A flag is set while its source is enabled and stays set until software clears it. The internal-error line has no flag and drives NMI directly while it is active.

Software reaches the block through a byte-wide I/O port pair. The system control/status port shows the two pending flags and the two per-source disable bits. The same port also carries the speaker data bit, the timer counter 2 gate, the timer counter 2 output and a bit that toggles on each refresh event. The RTC index port holds a global NMI mask in bit 7. Its lower seven bits are stored separately and passed to the RTC logic. To clear a flag, software writes 1 to the matching disable bit and then writes 0.

Each latched source is governed by its own state machine with three states. OFF means the source is disabled and its flag is clear. ARMED means the source is enabled and waiting for a request. HELD means a request has been latched. The transitions are:
- arm: OFF to ARMED, on a control write with the disable bit at 0.
- catch: ARMED to HELD, on a synchronized active request.
- disarm: ARMED to OFF, on a control write with the disable bit at 1.
- clear: HELD to OFF, on a control write with the disable bit at 1.

A control write with the disable bit at 0 leaves a HELD source in HELD.

Top module: `nmi_ctrl_top`

## Requirements
- R1: After reset, NMI is low, speaker and gate outputs are 0, the control port (address 0x61) reads 0x0C (both disable bits, bit 3 and bit 2, set; all flags clear; bit 4 is 0; bit 5 follows the timer output, 0 here), and the index port (address 0x70) reads 0x80.
- R2: While the channel-check source is enabled (bit 3 = 0), driving the channel-check input low sets pending bit 6 of the control port on the third clock edge. The bit stays set after the input returns high.
- R3: While the parity source is enabled (bit 2 = 0), driving either the system-error input or the parity-error input low sets pending bit 7 on the third clock edge.
- R4: Writing 1 to a disable bit (bit 3 for channel check, bit 2 for parity) clears that source's pending bit on the write edge. The disable bit then reads back 1, and requests on that source are ignored while it is disabled.
- R5: Writing 0 to a disable bit re-enables its source and reads back 0. If the request is still active, the pending bit is set again on the next edge.
- R6: While the internal-error input is high, NMI is asserted on the second clock edge if the mask is clear, and no pending bit is set.
- R7: NMI is high exactly when a pending bit is set or the synchronized internal-error input is high, and the global mask (bit 7 of port 0x70) is 0. Setting the mask drops NMI on the write edge and leaves the pending bits unchanged.
- R8: A write to port 0x70 stores bit 7 as the mask and bits 6:0 on the rtc_idx output. Port 0x70 reads back both fields.
- R9: Bit 4 of the control port inverts on each clock edge where refresh_tick is high, and holds otherwise. Bit 5 follows the tmr2_out input without delay.
- R10: Bits 1 and 0 of the control port are read/write and drive spkr_data and tmr2_gate. Writes to bits 7:4 have no effect.
- R11: A read of any address other than the two ports returns 0x00, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| iochk_n | input | 1 | I/O channel check request, active low |
| serr_n | input | 1 | PCI system error, active low |
| perr_n | input | 1 | PCI parity error, active low |
| cpu_ierr | input | 1 | Processor internal error, active high |
| refresh_tick | input | 1 | One-cycle pulse per refresh event |
| tmr2_out | input | 1 | Timer counter 2 output |
| spkr_data | output | 1 | Speaker data bit |
| tmr2_gate | output | 1 | Timer counter 2 gate |
| rtc_idx | output | 7 | RTC index bits |
| nmi | output | 1 | NMI request to the processor |

## Verification
The request inputs pass through two synchronizer flops and one state-register edge. A latched flag therefore appears on the third edge after its input changes. The internal-error path has no state register and reaches NMI on the second edge. Register writes, mask changes and refresh toggles take effect on the edge that takes the strobe. Bit 5 and all read data are combinational. The bench drives every input on the falling edge and samples one time step later. It then waits a counted number of rising edges before each check. For the request paths it checks both the edge before the result is due and the edge where it is due, so a path one stage too short or too long is reported.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_ARMED = 2'b01,
        SRC_HELD  = 2'b10
    } src_state_e;

    localparam int NUM_SRC    = 2;   // 0: parity, 1: channel check
    localparam int CTL_LSB    = 2;   // disable bit of source i = CTL_LSB + i
    localparam int STS_MSB    = 7;   // pending bit of source i = STS_MSB - i
    localparam int BIT_TMR2   = 5;
    localparam int BIT_REFR   = 4;
    localparam int BIT_SPKR   = 1;
    localparam int BIT_GATE   = 0;
    localparam int BIT_MASK   = 7;

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/nmi_src_fsm.sv
module nmi_src_fsm
    import nmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act,       // synchronized request, active high
    input  logic dis_wr,    // control write strobe
    input  logic dis_val,   // disable bit value in that write
    output logic pending,
    output logic disabled
);

    src_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_OFF: begin
                if (dis_wr && !dis_val) state_d = SRC_ARMED;      // arm
            end
            SRC_ARMED: begin
                if (dis_wr && dis_val)  state_d = SRC_OFF;        // disarm
                else if (act)           state_d = SRC_HELD;       // catch
            end
            SRC_HELD: begin
                if (dis_wr && dis_val)  state_d = SRC_OFF;        // clear
            end
            default:                    state_d = SRC_OFF;
        endcase
    end

    always_comb begin
        pending  = 1'b0;
        disabled = 1'b0;
        unique case (state_q)
            SRC_OFF:   disabled = 1'b1;
            SRC_ARMED: ;
            SRC_HELD:  pending  = 1'b1;
            default:   disabled = 1'b1;
        endcase
    end

    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && dis_val) |=> (!pending && disabled));                 // R4
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(dis_wr && dis_val)) |=> pending);                  // R2
    AST_ARM_CATCH:  assert property (@(posedge clk) disable iff (!rst_n)
        (!disabled && !pending && act && !dis_wr) |=> pending);          // R3
    AST_REARM:      assert property (@(posedge clk) disable iff (!rst_n)
        (disabled && dis_wr && !dis_val) |=> !disabled);                 // R5

endmodule

// File: rtl/nmi_ctrl_top.sv
module nmi_ctrl_top
    import nmi_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] SYSCTL_ADDR = 16'h0061,
    parameter logic [ADDR_W-1:0] RTCIDX_ADDR = 16'h0070,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              iochk_n,
    input  logic              serr_n,
    input  logic              perr_n,
    input  logic              cpu_ierr,
    input  logic              refresh_tick,
    input  logic              tmr2_out,
    output logic              spkr_data,
    output logic              tmr2_gate,
    output logic [6:0]        rtc_idx,
    output logic              nmi
);

    localparam int SYNC_W = 4;   // {ierr, iochk_n, serr_n, perr_n}

    logic [SYNC_W-1:0] raw_in, syn_in;
    logic              ierr_s;
    logic [NUM_SRC-1:0] src_act, src_pend, src_dis;

    logic sys_hit, idx_hit, sys_wr, idx_wr;
    logic mask_q, ref_q, spkr_q, gate_q;
    logic [6:0] idx_q;
    logic [7:0] sys_byte, idx_byte;

    assign raw_in = {cpu_ierr, iochk_n, serr_n, perr_n};

    nmi_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign ierr_s     = syn_in[3];
    assign src_act[0] = ~syn_in[1] | ~syn_in[0];   // parity: system or parity error
    assign src_act[1] = ~syn_in[2];                // channel check

    assign sys_hit = (bus_addr == SYSCTL_ADDR);
    assign idx_hit = (bus_addr == RTCIDX_ADDR);
    assign sys_wr  = bus_wr && sys_hit;
    assign idx_wr  = bus_wr && idx_hit;

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_src
            nmi_src_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .act      (src_act[i]),
                .dis_wr   (sys_wr),
                .dis_val  (bus_wdata[CTL_LSB+i]),
                .pending  (src_pend[i]),
                .disabled (src_dis[i])
            );
        end
    endgenerate

    // plain control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spkr_q <= 1'b0;
            gate_q <= 1'b0;
        end else if (sys_wr) begin
            spkr_q <= bus_wdata[BIT_SPKR];
            gate_q <= bus_wdata[BIT_GATE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            ref_q <= 1'b0;
        else if (refresh_tick) ref_q <= ~ref_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            idx_q  <= '0;
        end else if (idx_wr) begin
            mask_q <= bus_wdata[BIT_MASK];
            idx_q  <= bus_wdata[6:0];
        end
    end

    always_comb begin
        sys_byte = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            sys_byte[STS_MSB-k] = src_pend[k];
            sys_byte[CTL_LSB+k] = src_dis[k];
        end
        sys_byte[BIT_TMR2] = tmr2_out;
        sys_byte[BIT_REFR] = ref_q;
        sys_byte[BIT_SPKR] = spkr_q;
        sys_byte[BIT_GATE] = gate_q;
        idx_byte = {mask_q, idx_q};
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sys_hit)      bus_rdata = sys_byte;
        else if (bus_rd && idx_hit) bus_rdata = idx_byte;
    end

    assign nmi       = ~mask_q & ((|src_pend) | ierr_s);
    assign spkr_data = spkr_q;
    assign tmr2_gate = gate_q;
    assign rtc_idx   = idx_q;

    AST_MASK_BLOCKS:   assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && bus_wdata[BIT_MASK]) |=> !nmi);                       // R7
    AST_REFR_TOGGLE:   assert property (@(posedge clk) disable iff (!rst_n)
        refresh_tick |=> (ref_q != $past(ref_q)));                       // R9
    AST_REFR_STABLE:   assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_tick |=> $stable(ref_q));                               // R9
    AST_IDX_KEPT:      assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (rtc_idx == $past(bus_wdata[6:0])));                  // R8
    AST_IERR_NO_FLAG:  assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend == '0 && !src_act[0] && !src_act[1]) |=> $stable(src_pend)); // R6

endmodule

// File: tb/nmi_ctrl_top_tb.sv
module nmi_ctrl_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_SYS = 16'h0061;
    localparam logic [15:0] A_IDX = 16'h0070;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        iochk_n, serr_n, perr_n, cpu_ierr, refresh_tick, tmr2_out;
    logic        spkr_data, tmr2_gate, nmi;
    logic [6:0]  rtc_idx;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iochk_n(iochk_n), .serr_n(serr_n), .perr_n(perr_n),
        .cpu_ierr(cpu_ierr), .refresh_tick(refresh_tick), .tmr2_out(tmr2_out),
        .spkr_data(spkr_data), .tmr2_gate(tmr2_gate), .rtc_idx(rtc_idx),
        .nmi(nmi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_SYS, v); chk("R1 ctl port", v, 8'h0C);
        rd(A_IDX, v); chk("R1 idx port", v, 8'h80);
        chk("R1 nmi", {7'd0, nmi}, 8'h00);
        chk("R1 spkr/gate", {6'd0, spkr_data, tmr2_gate}, 8'h00);
    endtask

    task automatic t_iochk();
        logic [7:0] v;
        wr(A_SYS, 8'h00); wr(A_IDX, 8'h00);
        iochk_n = 1'b0;
        cyc(2);
        rd(A_SYS, v); chk("R2 not yet latched", v & 8'h40, 8'h00);
        chk("R2 nmi not yet", {7'd0, nmi}, 8'h00);
        cyc(1);
        rd(A_SYS, v); chk("R2 latched", v & 8'h40, 8'h40);
        chk("R7 nmi from flag", {7'd0, nmi}, 8'h01);
        iochk_n = 1'b1;
        cyc(5);
        rd(A_SYS, v); chk("R2 holds", v & 8'h40, 8'h40);
        wr(A_SYS, 8'h08);
        rd(A_SYS, v); chk("R4 clear and disable", v & 8'h48, 8'h08);
        chk("R4 nmi drops", {7'd0, nmi}, 8'h00);
        wr(A_SYS, 8'h00);
        cyc(1);
        rd(A_SYS, v); chk("R5 re-enabled idle", v & 8'h48, 8'h00);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        serr_n = 1'b0;
        cyc(2);
        rd(A_SYS, v); chk("R3 serr not yet", v & 8'h80, 8'h00);
        cyc(1);
        rd(A_SYS, v); chk("R3 serr latched", v & 8'hC0, 8'h80);
        serr_n = 1'b1; cyc(3);
        wr(A_SYS, 8'h04); wr(A_SYS, 8'h00);
        rd(A_SYS, v); chk("R5 parity cleared", v & 8'h84, 8'h00);
        perr_n = 1'b0;
        cyc(3);
        rd(A_SYS, v); chk("R3 perr latched", v & 8'hC0, 8'h80);
        chk("R3 nmi", {7'd0, nmi}, 8'h01);
        perr_n = 1'b1; cyc(3);
        wr(A_SYS, 8'h04); wr(A_SYS, 8'h00);
        rd(A_SYS, v); chk("R4 parity cleared", v & 8'h80, 8'h00);
    endtask

    task automatic t_disabled_ignored();
        logic [7:0] v;
        wr(A_SYS, 8'h0C);
        iochk_n = 1'b0; serr_n = 1'b0;
        cyc(5);
        rd(A_SYS, v); chk("R4 disabled ignored", v & 8'hC0, 8'h00);
        chk("R4 nmi low", {7'd0, nmi}, 8'h00);
        iochk_n = 1'b1; serr_n = 1'b1;
        cyc(3);
        wr(A_SYS, 8'h00);
        cyc(2);
        rd(A_SYS, v); chk("R5 no stale flag", v & 8'hCC, 8'h00);
    endtask

    task automatic t_relatch();
        logic [7:0] v;
        iochk_n = 1'b0;
        cyc(3);
        wr(A_SYS, 8'h08);
        rd(A_SYS, v); chk("R4 cleared while active", v & 8'h40, 8'h00);
        wr(A_SYS, 8'h00);
        rd(A_SYS, v); chk("R5 armed, not yet", v & 8'h48, 8'h00);
        cyc(1);
        rd(A_SYS, v); chk("R5 relatched", v & 8'h40, 8'h40);
        iochk_n = 1'b1; cyc(3);
        wr(A_SYS, 8'h08); wr(A_SYS, 8'h00);
    endtask

    task automatic t_ierr();
        logic [7:0] v;
        cpu_ierr = 1'b1;
        cyc(1);
        chk("R6 nmi not yet", {7'd0, nmi}, 8'h00);
        cyc(1);
        chk("R6 nmi set", {7'd0, nmi}, 8'h01);
        rd(A_SYS, v); chk("R6 no flag", v & 8'hC0, 8'h00);
        cpu_ierr = 1'b0;
        cyc(2);
        chk("R6 nmi released", {7'd0, nmi}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        iochk_n = 1'b0; cyc(3); iochk_n = 1'b1; cyc(3);
        chk("R7 nmi on", {7'd0, nmi}, 8'h01);
        wr(A_IDX, 8'h80);
        chk("R7 masked", {7'd0, nmi}, 8'h00);
        rd(A_SYS, v); chk("R7 flag kept", v & 8'h40, 8'h40);
        wr(A_IDX, 8'h00);
        chk("R7 unmasked", {7'd0, nmi}, 8'h01);
        wr(A_SYS, 8'h08); wr(A_SYS, 8'h00);
        cpu_ierr = 1'b1; wr(A_IDX, 8'h80); cyc(2);
        chk("R7 mask blocks ierr", {7'd0, nmi}, 8'h00);
        cpu_ierr = 1'b0; cyc(2); wr(A_IDX, 8'h00);
    endtask

    task automatic t_index();
        logic [7:0] v;
        wr(A_IDX, 8'h85);
        chk("R8 idx out", {1'b0, rtc_idx}, 8'h05);
        rd(A_IDX, v); chk("R8 idx read", v, 8'h85);
        wr(A_IDX, 8'h0A);
        chk("R8 idx out 2", {1'b0, rtc_idx}, 8'h0A);
        rd(A_IDX, v); chk("R8 idx read 2", v, 8'h0A);
        wr(A_IDX, 8'h00);
    endtask

    task automatic t_refresh();
        logic [7:0] v;
        logic       r;
        rd(A_SYS, v); r = v[4];
        for (int k = 0; k < 3; k++) begin
            refresh_tick = 1'b1; cyc(1); refresh_tick = 1'b0;
            r = ~r;
            rd(A_SYS, v); chk("R9 toggle", {7'd0, v[4]}, {7'd0, r});
        end
        cyc(2);
        rd(A_SYS, v); chk("R9 hold", {7'd0, v[4]}, {7'd0, r});
        tmr2_out = 1'b1;
        rd(A_SYS, v); chk("R9 timer out hi", v & 8'h20, 8'h20);
        tmr2_out = 1'b0;
        rd(A_SYS, v); chk("R9 timer out lo", v & 8'h20, 8'h00);
    endtask

    task automatic t_spkr();
        logic [7:0] v;
        wr(A_SYS, 8'h03);
        chk("R10 both set", {6'd0, spkr_data, tmr2_gate}, 8'h03);
        rd(A_SYS, v); chk("R10 readback", v & 8'h03, 8'h03);
        wr(A_SYS, 8'h02);
        chk("R10 spkr only", {6'd0, spkr_data, tmr2_gate}, 8'h02);
        wr(A_SYS, 8'hF0);
        rd(A_SYS, v); chk("R10 upper bits ignored", v & 8'hEF, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(A_SYS, 8'h01);
        wr(16'h0062, 8'hFF);
        rd(A_SYS, v); chk("R11 ctl untouched", v & 8'hCF, 8'h01);
        rd(16'h0062, v); chk("R11 read zero", v, 8'h00);
        wr(16'h0071, 8'h8F);
        rd(A_IDX, v); chk("R11 idx untouched", v, 8'h00);
        chk("R11 rtc_idx untouched", {1'b0, rtc_idx}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        iochk_n = 1'b1; serr_n = 1'b1; perr_n = 1'b1; cpu_ierr = 1'b0;
        refresh_tick = 1'b0; tmr2_out = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_iochk();
        t_parity();
        t_disabled_ignored();
        t_relatch();
        t_ierr();
        t_mask();
        t_index();
        t_refresh();
        t_spkr();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule